// File: doc/BRIEF.md
# Two-Level Warp Issue Scheduler

The scheduler picks at most one warp per cycle to issue from a fixed pool of warp contexts. Only a bounded subset of the pool, the active set, competes for issue. The active set is held in a small table of slots, and a rotating pointer scans those slots in loose round-robin order: a slot whose warp is not ready is skipped, and the next ready one wins in the same cycle. Every other warp is pending. A pending warp is either waiting for a long-latency result or eligible to run again.

When the granted warp issues a long-latency instruction, the issue stage raises `long_lat_i` in the same cycle as the grant. The warp then leaves its slot and waits. The memory side later reports completion with a warp ID. This makes the warp eligible and appends it to an age queue. Free slots are refilled from the head of that queue, one warp per cycle, so the oldest returned warp rejoins first. Warps therefore move both ways between the two groups while the block runs. Compute-bound warps keep the issue slots busy while the others wait on memory.

Top module: `twl_sched`

## Requirements
- R1: After reset, slot s (0 to ACT_SLOTS-1) holds warp s. Warps ACT_SLOTS to NUM_WARPS-1 are eligible-pending, queued in ascending ID order. The pointer is at slot 0.
- R2: A grant names only an active warp whose `ready_i` bit is 1. When no active warp is ready, `gnt_vld_o` is 0.
- R3: The grant goes to the first slot holding a ready warp, scanning from the pointer slot upward with wrap-around. It is combinational in the same cycle as `ready_i`.
- R4: After a grant from slot s, the pointer moves to slot (s+1) mod ACT_SLOTS. With no grant, the pointer holds.
- R5: If `long_lat_i` is 1 in a grant cycle, the granted warp leaves its slot at that edge and becomes waiting-pending. It is not granted again until it has returned and been readmitted.
- R6: A completion (`done_vld_i`=1, `done_wid_i`=w) for a waiting warp w makes w eligible and appends it to the tail of the age queue.
- R7: A completion for a warp that is not waiting has no effect. This covers active warps, eligible warps, and a warp being granted with `long_lat_i` in the same cycle. In that last case issue wins and the warp stays waiting.
- R8: A slot vacated by R5 is refilled at the same edge from the queue head, and the new warp keeps that slot's position. Otherwise, with the queue non-empty, the lowest-numbered empty slot is filled. At most one warp is admitted per cycle. A warp completed in a cycle is not admitted in that same cycle.
- R9: Eligible warps enter the active set in the order in which they became eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ready_i | input | NUM_WARPS | Per-warp ready flag, bit w for warp w |
| long_lat_i | input | 1 | Granted warp issues a long-latency instruction this cycle |
| done_vld_i | input | 1 | Long-latency completion event |
| done_wid_i | input | $clog2(NUM_WARPS) | Warp ID of the completion |
| gnt_vld_o | output | 1 | A warp is granted this cycle |
| gnt_wid_o | output | $clog2(NUM_WARPS) | Granted warp ID |

## Verification
The grant is combinational, so it is due in the same cycle as `ready_i`. The bench drives inputs at the falling edge and samples the grant 1 ns later. A retirement, completion or refill takes effect at the next rising edge and appears in the grant of the following cycle. A completed warp needs one more edge to leave the queue before it can be granted. A small configuration (8 warps, 3 slots) is checked every cycle against an arithmetic model of the slot table, pointer and age queue, kept in the bench. The model is advanced between the sample point and the rising edge.

// File: rtl/twl_pkg.sv
package twl_pkg;
  // Increment with wrap for any modulus
  function automatic int wrap_inc(input int v, input int n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction
endpackage

// File: rtl/twl_rr_pick.sv
module twl_rr_pick #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] ptr_i,
  output logic          vld_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    for (int k = 0; k < N; k++) begin
      int c;
      c = int'(ptr_i) + k;
      if (c >= N) c = c - N;
      if (!vld_o && req_i[c]) begin
        vld_o = 1'b1;
        idx_o = IW'(c);
      end
    end
  end
endmodule

// File: rtl/twl_age_fifo.sv
module twl_age_fifo #(
  parameter int DEPTH     = 32,
  parameter int W         = 5,
  parameter int INIT_CNT  = 24,
  parameter int INIT_BASE = 8,
  localparam int PW       = $clog2(DEPTH),
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic [CW-1:0] cnt_o
);
  import twl_pkg::*;

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;

  assign head_o  = mem_q[rd_q];
  assign empty_o = (cnt_q == '0);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++)
        mem_q[i] <= (i < INIT_CNT) ? W'(INIT_BASE + i) : '0;
      rd_q  <= '0;
      wr_q  <= PW'(INIT_CNT % DEPTH);
      cnt_q <= CW'(INIT_CNT);
    end else begin
      if (push_i) begin
        mem_q[wr_q] <= push_data_i;
        wr_q        <= PW'(wrap_inc(int'(wr_q), DEPTH));
      end
      if (pop_i && !empty_o) rd_q <= PW'(wrap_inc(int'(rd_q), DEPTH));
      case ({push_i, pop_i && !empty_o})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/twl_sched.sv
module twl_sched #(
  parameter int NUM_WARPS = 32,
  parameter int ACT_SLOTS = 8,
  localparam int WW = $clog2(NUM_WARPS),
  localparam int SW = $clog2(ACT_SLOTS),
  localparam int CW = $clog2(NUM_WARPS + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_WARPS-1:0] ready_i,
  input  logic                 long_lat_i,
  input  logic                 done_vld_i,
  input  logic [WW-1:0]        done_wid_i,
  output logic                 gnt_vld_o,
  output logic [WW-1:0]        gnt_wid_o
);
  import twl_pkg::*;

  logic [ACT_SLOTS-1:0] slot_vld_q;
  logic [WW-1:0]        slot_wid_q [ACT_SLOTS];
  logic [SW-1:0]        ptr_q;
  logic [NUM_WARPS-1:0] wait_q;

  logic [ACT_SLOTS-1:0] slot_req;
  logic [SW-1:0]        gnt_slot;
  logic                 retire, done_ok, fill_go, any_free;
  logic [SW-1:0]        free_slot, fill_slot;
  logic [WW-1:0]        q_head;
  logic                 q_empty;
  logic [CW-1:0]        q_cnt;

  for (genvar s = 0; s < ACT_SLOTS; s++) begin : g_req
    assign slot_req[s] = slot_vld_q[s] & ready_i[slot_wid_q[s]];
  end

  twl_rr_pick #(.N(ACT_SLOTS), .IW(SW)) i_pick (
    .req_i (slot_req),
    .ptr_i (ptr_q),
    .vld_o (gnt_vld_o),
    .idx_o (gnt_slot)
  );

  assign gnt_wid_o = slot_wid_q[gnt_slot];
  assign retire    = gnt_vld_o & long_lat_i;
  // Granted warp is active, so its wait bit is clear: issue wins by construction
  assign done_ok   = done_vld_i & wait_q[done_wid_i];

  always_comb begin
    any_free  = 1'b0;
    free_slot = '0;
    for (int s = ACT_SLOTS - 1; s >= 0; s--) begin
      if (!slot_vld_q[s]) begin
        any_free  = 1'b1;
        free_slot = SW'(s);
      end
    end
  end

  assign fill_go   = !q_empty && (retire || any_free);
  assign fill_slot = retire ? gnt_slot : free_slot;

  twl_age_fifo #(
    .DEPTH     (NUM_WARPS),
    .W         (WW),
    .INIT_CNT  (NUM_WARPS - ACT_SLOTS),
    .INIT_BASE (ACT_SLOTS)
  ) i_queue (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (done_ok),
    .push_data_i (done_wid_i),
    .pop_i       (fill_go),
    .head_o      (q_head),
    .empty_o     (q_empty),
    .cnt_o       (q_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_vld_q <= '1;
      for (int s = 0; s < ACT_SLOTS; s++) slot_wid_q[s] <= WW'(s);
      ptr_q  <= '0;
      wait_q <= '0;
    end else begin
      if (retire) slot_vld_q[gnt_slot] <= 1'b0;
      if (fill_go) begin
        slot_vld_q[fill_slot] <= 1'b1;
        slot_wid_q[fill_slot] <= q_head;
      end
      if (done_ok) wait_q[done_wid_i] <= 1'b0;
      if (retire)  wait_q[gnt_wid_o]  <= 1'b1;
      if (gnt_vld_o) ptr_q <= SW'(wrap_inc(int'(gnt_slot), ACT_SLOTS));
    end
  end
endmodule

// File: rtl/twl_sched_chk.sv
module twl_sched_chk #(
  parameter int NUM_WARPS = 32,
  parameter int ACT_SLOTS = 8,
  localparam int WW = $clog2(NUM_WARPS),
  localparam int SW = $clog2(ACT_SLOTS),
  localparam int CW = $clog2(NUM_WARPS + 1)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_WARPS-1:0] ready_i,
  input logic                 long_lat_i,
  input logic                 gnt_vld_o,
  input logic [WW-1:0]        gnt_wid_o,
  input logic [SW-1:0]        ptr_q,
  input logic [ACT_SLOTS-1:0] slot_vld_q,
  input logic [NUM_WARPS-1:0] wait_q,
  input logic [CW-1:0]        q_cnt
);
  assert_grant_ready_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_vld_o |-> ready_i[gnt_wid_o]);

  assert_idle_no_grant_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i == '0) |-> !gnt_vld_o);

  assert_ptr_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gnt_vld_o |=> $stable(ptr_q));

  assert_retired_not_regranted_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_vld_o && long_lat_i) |=> !(gnt_vld_o && gnt_wid_o == $past(gnt_wid_o)));

  // Every warp sits in exactly one place: a slot, the wait set, or the queue
  assert_warp_conserved_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(slot_vld_q) + $countones(wait_q) + int'(q_cnt)) == NUM_WARPS);
endmodule

bind twl_sched twl_sched_chk #(.NUM_WARPS(NUM_WARPS), .ACT_SLOTS(ACT_SLOTS)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ready_i    (ready_i),
  .long_lat_i (long_lat_i),
  .gnt_vld_o  (gnt_vld_o),
  .gnt_wid_o  (gnt_wid_o),
  .ptr_q      (ptr_q),
  .slot_vld_q (slot_vld_q),
  .wait_q     (wait_q),
  .q_cnt      (q_cnt)
);

// File: tb/test_twl_sched.sv
module test_twl_sched;
  localparam int NW = 8;
  localparam int NA = 3;
  localparam int WW = $clog2(NW);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NW-1:0] ready_i = '0;
  logic          long_lat_i = 1'b0;
  logic          done_vld_i = 1'b0;
  logic [WW-1:0] done_wid_i = '0;
  logic          gnt_vld_o;
  logic [WW-1:0] gnt_wid_o;

  int checks = 0;
  int failures = 0;

  always #5 clk_i = ~clk_i;

  twl_sched #(.NUM_WARPS(NW), .ACT_SLOTS(NA)) i_twl_sched (
    .clk_i, .rst_ni, .ready_i, .long_lat_i, .done_vld_i, .done_wid_i,
    .gnt_vld_o, .gnt_wid_o
  );

  // Requirement model
  bit m_vld [NA];
  int m_wid [NA];
  int m_ptr;
  bit m_wait [NW];
  int mq [NW];
  int mqn;

  function automatic void model_reset();
    for (int s = 0; s < NA; s++) begin m_vld[s] = 1; m_wid[s] = s; end
    m_ptr = 0;
    for (int w = 0; w < NW; w++) m_wait[w] = 0;
    mqn = 0;
    for (int w = NA; w < NW; w++) begin mq[mqn] = w; mqn++; end
  endfunction

  function automatic int exp_slot(input logic [NW-1:0] rdy);
    for (int k = 0; k < NA; k++) begin
      int c;
      c = (m_ptr + k) % NA;
      if (m_vld[c] && rdy[m_wid[c]]) return c;
    end
    return -1;
  endfunction

  task automatic check(input string tag, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One cycle: drive, sample, advance model. dw<0 means "the warp granted now".
  task automatic step(input logic [NW-1:0] rdy, input bit ll, input bit dv, input int dw,
                      input string tag);
    int es, ew, fs;
    bit retire, dok;
    @(negedge clk_i);
    es = exp_slot(rdy);
    ew = (es >= 0) ? m_wid[es] : 0;
    if (dw < 0) dw = ew;
    ready_i = rdy; long_lat_i = ll; done_vld_i = dv; done_wid_i = WW'(dw);
    #1;
    check({tag, " gnt_vld"}, gnt_vld_o == (es >= 0), int'(gnt_vld_o), int'(es >= 0));
    if (es >= 0)
      check({tag, " gnt_wid"}, int'(gnt_wid_o) == ew, int'(gnt_wid_o), ew);
    retire = (es >= 0) && ll;
    dok = dv && m_wait[dw];
    fs = -1;
    for (int s = NA - 1; s >= 0; s--) if (!m_vld[s]) fs = s;
    if (retire) begin m_vld[es] = 0; m_wait[ew] = 1; end
    if (mqn > 0 && (retire || fs >= 0)) begin
      int t;
      t = retire ? es : fs;
      m_vld[t] = 1; m_wid[t] = mq[0];
      for (int i = 0; i < NW - 1; i++) mq[i] = mq[i + 1];
      mqn--;
    end
    if (dok) begin m_wait[dw] = 0; mq[mqn] = dw; mqn++; end
    if (es >= 0) m_ptr = (es + 1) % NA;
  endtask

  task automatic lit(input string tag, input bit vld, input int wid);
    check({tag, " lit_vld"}, gnt_vld_o == vld, int'(gnt_vld_o), int'(vld));
    if (vld) check({tag, " lit_wid"}, int'(gnt_wid_o) == wid, int'(gnt_wid_o), wid);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1'b1;

    // R1: reset membership and pointer
    step('1, 0, 0, 0, "R1"); lit("R1", 1, 0);
    step('1, 0, 0, 0, "R1"); lit("R1", 1, 1);
    step('1, 0, 0, 0, "R1"); lit("R1", 1, 2);
    step('1, 0, 0, 0, "R1"); lit("R1", 1, 0);

    // R2: nothing ready, or only pending warps ready
    step('0, 0, 0, 0, "R2"); lit("R2", 0, 0);
    step(8'hF8, 0, 0, 0, "R2"); lit("R2", 0, 0);

    // R3/R4: skip unready, pointer after grant, hold without grant
    step(8'h04, 0, 0, 0, "R3"); lit("R3", 1, 2);
    step(8'h00, 0, 0, 0, "R4");
    step(8'h07, 0, 0, 0, "R4"); lit("R4", 1, 0);
    step(8'h05, 0, 0, 0, "R4"); lit("R4", 1, 2);

    // R5/R8: retire warp 0 (slot 0), queue head 3 takes slot 0
    step(8'h01, 1, 0, 0, "R5"); lit("R5", 1, 0);
    step(8'h01, 0, 0, 0, "R5"); lit("R5", 0, 0);
    step(8'h08, 0, 0, 0, "R8"); lit("R8", 1, 3);

    // R7: completion for an active warp is ignored
    step('0, 0, 1, 1, "R7");
    // R7: issue wins over a same-cycle completion
    step(8'h02, 1, 1, -1, "R7"); lit("R7", 1, 1);
    step(8'h02, 0, 0, 0, "R7"); lit("R7", 0, 0);

    // R6/R9: drain queue by retirements, then complete 1 then 0 and check order
    for (int i = 0; i < 6; i++) step('1, 1, 0, 0, "R8");
    step('0, 0, 1, 1, "R6");
    step('0, 0, 1, 0, "R9");
    for (int i = 0; i < 6; i++) step('1, 1, (i == 0), 4, "R9");
    for (int i = 0; i < 4; i++) step('1, 0, 0, 0, "R9");

    // R8: mixed traffic sweep against the model
    for (int i = 0; i < 4000; i++) begin
      int dw;
      bit dv;
      dv = ($urandom_range(0, 1) == 1);
      dw = $urandom_range(0, NW - 1);
      if ($urandom_range(0, 7) == 0) dw = -1;
      step(NW'($urandom) | NW'($urandom), ($urandom_range(0, 3) == 0), dv, dw, "R8");
    end

    summary();
    $finish;
  end
endmodule